// File: doc/BRIEF.md
# Configurable PLD Macrocell Register

This block is one logic cell of a programmable-logic fabric. A small set of product-term inputs is ORed, the sum passes through a two-input XOR whose second leg is chosen by configuration (constant low, constant high for polarity inversion, or a separate product term for arithmetic functions), and the result reaches a storage element. That element is configured as a D, T, JK or SR flip-flop or as a transparent latch. It can also be bypassed so the cell output is purely combinational. Secondary product terms supply an auxiliary data input (K or R), an active-low preset, an active-low clear, a clock term and an output enable.

The fabric runs on one system clock `clk`. In global-clock mode the storage element updates on every rising edge of `clk`. In array-clock mode the clock product term `pt_clk` is sampled on `clk`, and the element updates only on the `clk` edge at which the sampled term shows the selected transition (rising or falling). Preset and clear act on the cell output in the same cycle they are asserted, without waiting for a clock, and are written into the stored state at the next `clk` edge. The cell drives a pad output with an active-high enable. It returns two independent feedbacks: one from the cell result and one from the pad.

Top module: `pld_macrocell`

## Requirements
- R1: The XOR input is the OR of all `pt_sum` bits XORed with a second leg chosen by `cfg_xsel`: 0 selects constant 0, 1 selects constant 1, and 2 or 3 selects `pt_xor`.
- R2: With `cfg_mode` 5 (bypass; codes 6 and 7 behave the same), `mc_fb` equals the XOR output in the same cycle, and preset and clear have no effect on it.
- R3: With `cfg_mode` 0 (D), the stored state takes the XOR output at each enabled clock edge.
- R4: With `cfg_mode` 1 (T), an enabled edge inverts the stored state when the XOR output is 1 and keeps it when it is 0.
- R5: With `cfg_mode` 2 (JK), J is the XOR output and K is `pt_aux`. At an enabled edge, J only sets, K only clears, both toggle, and neither holds.
- R6: With `cfg_mode` 3 (SR), S is the XOR output and R is `pt_aux`. At an edge, S only sets and R only clears. Both set or both clear leave the state unchanged.
- R7: With `cfg_mode` 4 (latch), the gate is `pt_clk` XOR `cfg_clk_neg`. While the gate is 1, `mc_fb` follows the XOR output in the same cycle and the stored state tracks it at each `clk` edge. While the gate is 0, the state holds.
- R8: With `cfg_clk_array` 0, every rising edge of `clk` is an enabled edge for the flip-flop modes.
- R9: With `cfg_clk_array` 1, an enabled edge is a `clk` edge at which `pt_clk` has changed since the previous `clk` edge. The change must be 0 to 1 when `cfg_clk_neg` is 0, and 1 to 0 when it is 1. No other edge changes a flip-flop.
- R10: In the storage modes (codes 0 to 4), `clear_n` low drives `mc_fb` to 0 at once and `preset_n` low drives it to 1 at once. Clear wins when both are low. The forced value is written into the stored state at each `clk` edge while the term is held.
- R11: `pin_oe` follows `pt_oe`, and `pin_o` carries the cell result `mc_fb`.
- R12: `io_fb` equals `pin_o` while `pin_oe` is 1 and `pin_i` otherwise, independent of `mc_fb` when the pad is an input.
- R13: While `rst_n` is low, the stored state and the clock-term history are 0. Release passes through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the global clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Storage mode: 0 D, 1 T, 2 JK, 3 SR, 4 latch, 5-7 bypass |
| cfg_xsel | input | 2 | Second XOR leg: 0 zero, 1 one, 2/3 `pt_xor` |
| cfg_clk_array | input | 1 | 1 selects the product-term clock |
| cfg_clk_neg | input | 1 | 1 selects falling edge / low-active latch gate |
| pt_sum | input | NUM_PT | Product terms that are ORed |
| pt_xor | input | 1 | Product term for the second XOR leg |
| pt_aux | input | 1 | Secondary data term (K or R) |
| pt_clk | input | 1 | Clock product term |
| preset_n | input | 1 | Active-low preset term |
| clear_n | input | 1 | Active-low clear term |
| pt_oe | input | 1 | Output-enable product term |
| pin_i | input | 1 | Value seen on the pad |
| pin_o | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Active-high pad driver enable |
| mc_fb | output | 1 | Cell result feedback |
| io_fb | output | 1 | Pad feedback |

## Verification
The bench pins down the two tie cases: both JK inputs set, which must toggle, and both SR inputs set, which must hold. A design that swapped these would flip or stall the cell on exactly those vectors. It asserts preset and clear together and expects a 0. A reversed priority would read 1. It also checks that a forced value persists after the term is released, which a design that only masked the output would lose. It walks the product-term clock through both edge polarities with steady stretches between edges. A wrong edge choice, or an update on every system edge, shows up as early or missing captures. Bypass vectors carry active preset and clear, which must not reach the output. Latch vectors open and close the gate to catch a latch that misses transparency or leaks while closed.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [2:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4,
    MODE_COMB  = 3'd5
  } mc_mode_e;

  localparam logic [1:0] XSEL_ZERO = 2'd0;
  localparam logic [1:0] XSEL_ONE  = 2'd1;

  function automatic logic is_bypass(input logic [2:0] m);
    return (m > 3'd4);
  endfunction
endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/mc_pterm_logic.sv
module mc_pterm_logic #(
  parameter int NUM_PT = 3
) (
  input  logic [NUM_PT-1:0] pt_sum,
  input  logic              pt_xor,
  input  logic [1:0]        cfg_xsel,
  output logic              xr_out
);
  import mc_pkg::*;

  logic or_sum;
  logic leg_b;

  always_comb begin
    or_sum = 1'b0;
    for (int i = 0; i < NUM_PT; i++) begin
      or_sum = or_sum | pt_sum[i];
    end
  end

  always_comb begin
    unique case (cfg_xsel)
      XSEL_ZERO: leg_b = 1'b0;
      XSEL_ONE:  leg_b = 1'b1;
      default:   leg_b = pt_xor;
    endcase
  end

  assign xr_out = or_sum ^ leg_b;
endmodule

// File: rtl/mc_clk_ctrl.sv
module mc_clk_ctrl (
  input  logic clk,
  input  logic rst_q_n,
  input  logic cfg_clk_array,
  input  logic cfg_clk_neg,
  input  logic pt_clk,
  output logic tick,
  output logic gate
);
  logic prev_q;
  logic prev_d;
  logic rise;
  logic fall;

  always_comb begin
    prev_d = pt_clk;
    rise   = ~prev_q & pt_clk;
    fall   = prev_q & ~pt_clk;
    if (cfg_clk_array) tick = cfg_clk_neg ? fall : rise;
    else               tick = 1'b1;
    gate = pt_clk ^ cfg_clk_neg;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) prev_q <= 1'b0;
    else          prev_q <= prev_d;
  end
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic       clk,
  input  logic       rst_q_n,
  input  logic [2:0] cfg_mode,
  input  logic       tick,
  input  logic       gate,
  input  logic       d_in,
  input  logic       aux_in,
  input  logic       preset_n,
  input  logic       clear_n,
  output logic       q_vis
);
  import mc_pkg::*;

  mc_mode_e mode;
  logic     state_q;
  logic     state_d;
  logic     ff_next;
  logic     upd_en;

  assign mode = mc_mode_e'(cfg_mode);

  always_comb begin
    unique case (mode)
      MODE_D:  ff_next = d_in;
      MODE_T:  ff_next = state_q ^ d_in;
      MODE_JK: begin
        unique case ({d_in, aux_in})
          2'b10:   ff_next = 1'b1;
          2'b01:   ff_next = 1'b0;
          2'b11:   ff_next = ~state_q;
          default: ff_next = state_q;
        endcase
      end
      MODE_SR: begin
        unique case ({d_in, aux_in})
          2'b10:   ff_next = 1'b1;
          2'b01:   ff_next = 1'b0;
          default: ff_next = state_q;
        endcase
      end
      MODE_LATCH: ff_next = d_in;
      default:    ff_next = state_q;
    endcase
  end

  always_comb begin
    if (mode == MODE_LATCH)     upd_en = gate;
    else if (cfg_mode <= 3'd3)  upd_en = tick;
    else                        upd_en = 1'b0;
  end

  always_comb begin
    if (!clear_n)       state_d = 1'b0;
    else if (!preset_n) state_d = 1'b1;
    else if (upd_en)    state_d = ff_next;
    else                state_d = state_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) state_q <= 1'b0;
    else          state_q <= state_d;
  end

  always_comb begin
    if (is_bypass(cfg_mode))                 q_vis = d_in;
    else if (!clear_n)                       q_vis = 1'b0;
    else if (!preset_n)                      q_vis = 1'b1;
    else if ((mode == MODE_LATCH) && gate)   q_vis = d_in;
    else                                     q_vis = state_q;
  end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
  parameter int NUM_PT     = 3,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_mode,
  input  logic [1:0]        cfg_xsel,
  input  logic              cfg_clk_array,
  input  logic              cfg_clk_neg,
  input  logic [NUM_PT-1:0] pt_sum,
  input  logic              pt_xor,
  input  logic              pt_aux,
  input  logic              pt_clk,
  input  logic              preset_n,
  input  logic              clear_n,
  input  logic              pt_oe,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe,
  output logic              mc_fb,
  output logic              io_fb
);
  logic rst_q_n;
  logic xr_out;
  logic tick;
  logic gate;
  logic q_vis;

  mc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  mc_pterm_logic #(.NUM_PT(NUM_PT)) u_logic (
    .pt_sum   (pt_sum),
    .pt_xor   (pt_xor),
    .cfg_xsel (cfg_xsel),
    .xr_out   (xr_out)
  );

  mc_clk_ctrl u_clk (
    .clk           (clk),
    .rst_q_n       (rst_q_n),
    .cfg_clk_array (cfg_clk_array),
    .cfg_clk_neg   (cfg_clk_neg),
    .pt_clk        (pt_clk),
    .tick          (tick),
    .gate          (gate)
  );

  mc_store u_store (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .cfg_mode (cfg_mode),
    .tick     (tick),
    .gate     (gate),
    .d_in     (xr_out),
    .aux_in   (pt_aux),
    .preset_n (preset_n),
    .clear_n  (clear_n),
    .q_vis    (q_vis)
  );

  assign mc_fb  = q_vis;
  assign pin_o  = q_vis;
  assign pin_oe = pt_oe;
  assign io_fb  = pt_oe ? q_vis : pin_i;
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk (
  input logic       clk,
  input logic       rst_q_n,
  input logic [2:0] cfg_mode,
  input logic       cfg_clk_array,
  input logic       pt_clk,
  input logic       pt_aux,
  input logic       preset_n,
  input logic       clear_n,
  input logic       xr_out,
  input logic       mc_fb
);
  logic armed;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_mode > 3'd4) |-> (mc_fb == xr_out));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((cfg_mode <= 3'd4) && !clear_n) |-> (mc_fb == 1'b0));

  // R10
  preset_force_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((cfg_mode <= 3'd4) && clear_n && !preset_n) |-> (mc_fb == 1'b1));

  // R8
  global_d_capture_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && cfg_mode == 3'd0 && !cfg_clk_array && preset_n && clear_n &&
     $past(cfg_mode == 3'd0 && !cfg_clk_array && preset_n && clear_n))
    |-> (mc_fb == $past(xr_out)));

  // R9
  array_no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && cfg_mode == 3'd0 && cfg_clk_array && preset_n && clear_n &&
     pt_clk == $past(pt_clk))
    |=> (cfg_mode != 3'd0 || !preset_n || !clear_n || $stable(mc_fb)));

  // R6
  sr_both_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && cfg_mode == 3'd3 && !cfg_clk_array && preset_n && clear_n &&
     xr_out && pt_aux)
    |=> (cfg_mode != 3'd3 || !preset_n || !clear_n || $stable(mc_fb)));
endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .cfg_mode      (cfg_mode),
  .cfg_clk_array (cfg_clk_array),
  .pt_clk        (pt_clk),
  .pt_aux        (pt_aux),
  .preset_n      (preset_n),
  .clear_n       (clear_n),
  .xr_out        (xr_out),
  .mc_fb         (mc_fb)
);

// File: tb/tb_pld_macrocell.sv
module tb_pld_macrocell;
  localparam int CLK_PERIOD = 10;
  localparam int NPT = 3;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] cfg_mode;
  logic [1:0] cfg_xsel;
  logic cfg_clk_array, cfg_clk_neg;
  logic [NPT-1:0] pt_sum;
  logic pt_xor, pt_aux, pt_clk, preset_n, clear_n, pt_oe, pin_i;
  logic pin_o, pin_oe, mc_fb, io_fb;

  logic [2:0] n_mode;
  logic [1:0] n_xsel;
  logic n_arr, n_neg;
  logic [NPT-1:0] n_sum;
  logic n_xor, n_aux, n_clk, n_pre, n_clr, n_oe, n_pin;

  logic m_q, m_prev;
  int n_checks = 0;
  int n_fail = 0;
  string force_tag = "";

  pld_macrocell #(.NUM_PT(NPT)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_xsel(cfg_xsel),
    .cfg_clk_array(cfg_clk_array), .cfg_clk_neg(cfg_clk_neg), .pt_sum(pt_sum),
    .pt_xor(pt_xor), .pt_aux(pt_aux), .pt_clk(pt_clk), .preset_n(preset_n),
    .clear_n(clear_n), .pt_oe(pt_oe), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe(pin_oe), .mc_fb(mc_fb), .io_fb(io_fb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic f_xor(input logic [NPT-1:0] s, input logic [1:0] xs, input logic x);
    logic leg;
    leg = (xs == 2'd0) ? 1'b0 : (xs == 2'd1) ? 1'b1 : x;
    return (|s) ^ leg;
  endfunction

  function automatic logic f_vis(input logic [2:0] m, input logic q, input logic d,
                                 input logic g, input logic pre, input logic clr);
    if (m > 3'd4) return d;
    if (!clr) return 1'b0;
    if (!pre) return 1'b1;
    if (m == 3'd4 && g) return d;
    return q;
  endfunction

  function automatic logic f_next(input logic [2:0] m, input logic q, input logic d,
                                  input logic a, input logic en, input logic pre, input logic clr);
    if (!clr) return 1'b0;
    if (!pre) return 1'b1;
    if (!en) return q;
    case (m)
      3'd0: return d;
      3'd1: return d ? ~q : q;
      3'd2: return (d && a) ? ~q : d ? 1'b1 : a ? 1'b0 : q;
      3'd3: return (d && !a) ? 1'b1 : (a && !d) ? 1'b0 : q;
      3'd4: return d;
      default: return q;
    endcase
  endfunction

  function automatic string mode_tag(input logic [2:0] m, input logic clr, input logic pre);
    if (m > 3'd4) return "R2";
    if (!clr || !pre) return "R10";
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic d, g, tk, en, ev;
    @(negedge clk);
    cfg_mode = n_mode; cfg_xsel = n_xsel; cfg_clk_array = n_arr; cfg_clk_neg = n_neg;
    pt_sum = n_sum; pt_xor = n_xor; pt_aux = n_aux; pt_clk = n_clk;
    preset_n = n_pre; clear_n = n_clr; pt_oe = n_oe; pin_i = n_pin;
    #1;
    d  = f_xor(n_sum, n_xsel, n_xor);
    g  = n_clk ^ n_neg;
    tk = n_arr ? (n_neg ? (m_prev & ~n_clk) : (~m_prev & n_clk)) : 1'b1;
    en = (n_mode == 3'd4) ? g : (n_mode <= 3'd3) ? tk : 1'b0;
    ev = f_vis(n_mode, m_q, d, g, n_pre, n_clr);
    check((force_tag != "") ? force_tag : mode_tag(n_mode, n_clr, n_pre), mc_fb, ev);
    check("R11", pin_oe, n_oe);
    check("R11", pin_o, ev);
    check("R12", io_fb, n_oe ? ev : n_pin);
    @(posedge clk);
    #1;
    m_q = f_next(n_mode, m_q, d, n_aux, en, n_pre, n_clr);
    m_prev = n_clk;
  endtask

  task automatic idle_inputs();
    n_mode = 3'd0; n_xsel = 2'd0; n_arr = 1'b0; n_neg = 1'b0; n_sum = '0;
    n_xor = 1'b0; n_aux = 1'b0; n_clk = 1'b0; n_pre = 1'b1; n_clr = 1'b1;
    n_oe = 1'b1; n_pin = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    idle_inputs();
    rst_n = 1'b0;
    cfg_mode = 3'd0; cfg_xsel = 2'd0; cfg_clk_array = 1'b0; cfg_clk_neg = 1'b0;
    pt_sum = '0; pt_xor = 1'b0; pt_aux = 1'b0; pt_clk = 1'b0;
    preset_n = 1'b1; clear_n = 1'b1; pt_oe = 1'b1; pin_i = 1'b0;
    n_sum = 3'b111;
    m_q = 1'b0; m_prev = 1'b0;
    repeat (3) @(negedge clk);
    pt_sum = 3'b111;
    #1;
    // R13: held in reset, data present, output stays 0
    check("R13", mc_fb, 1'b0);
    check("R13", pin_o, 1'b0);
    clear_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    clear_n = 1'b1;
    pt_sum = '0;
    idle_inputs();

    // R1 polarity and arithmetic leg in bypass
    force_tag = "R1";
    n_mode = 3'd5;
    n_sum = 3'b000; n_xsel = 2'd0; step();
    n_sum = 3'b010; step();
    n_sum = 3'b000; n_xsel = 2'd1; step();
    n_sum = 3'b100; n_xsel = 2'd2; n_xor = 1'b1; step();
    n_sum = 3'b000; n_xsel = 2'd3; n_xor = 1'b1; step();
    // R2 bypass ignores preset/clear
    force_tag = "R2";
    n_xsel = 2'd0; n_sum = 3'b001; n_clr = 1'b0; n_pre = 1'b0; step();
    n_sum = 3'b000; n_clr = 1'b1; step();
    n_pre = 1'b1;
    // R10 both low, clear wins; then forced value persists
    force_tag = "R10";
    n_mode = 3'd0; n_sum = 3'b111; step();
    n_pre = 1'b0; n_clr = 1'b0; step();
    n_mode = 3'd3; n_sum = 3'b000; n_aux = 1'b0; n_clr = 1'b1; step();
    n_pre = 1'b1; step();
    // R6 SR both asserted holds
    force_tag = "R6";
    n_sum = 3'b001; n_aux = 1'b1; step(); step(); step();
    n_sum = 3'b000; step(); step();
    // R5 JK both asserted toggles
    force_tag = "R5";
    n_mode = 3'd2; n_sum = 3'b010; n_aux = 1'b1; step(); step(); step(); step();
    // R9 array clock, falling then rising
    force_tag = "R9";
    n_mode = 3'd0; n_aux = 1'b0; n_arr = 1'b1; n_neg = 1'b1; n_clk = 1'b1;
    n_sum = 3'b100; step(); step();
    n_clk = 1'b0; step(); step();
    n_sum = 3'b000; step(); step();
    n_neg = 1'b0; n_clk = 1'b1; step(); step();
    // R8 global clock captures every edge
    force_tag = "R8";
    n_arr = 1'b0; n_sum = 3'b001; step(); n_sum = 3'b000; step(); n_sum = 3'b010; step(); step();
    // R7 latch gate open then closed
    force_tag = "R7";
    n_mode = 3'd4; n_neg = 1'b0; n_clk = 1'b1; n_sum = 3'b000; step();
    n_sum = 3'b001; step();
    n_clk = 1'b0; n_sum = 3'b000; step(); step();
    n_neg = 1'b1; step(); step();
    // R12 pad as input
    force_tag = "R12";
    n_oe = 1'b0; n_pin = 1'b1; step(); n_pin = 1'b0; step();
    force_tag = "";

    // constrained random mix
    for (int blk = 0; blk < 200; blk++) begin
      n_mode = 3'($urandom_range(0, 5));
      n_xsel = 2'($urandom_range(0, 3));
      n_arr  = 1'($urandom_range(0, 1));
      n_neg  = 1'($urandom_range(0, 1));
      for (int v = 0; v < 16; v++) begin
        n_sum = ($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'b000;
        n_xor = 1'($urandom);
        n_aux = 1'($urandom);
        if ($urandom_range(0, 2) == 0) n_clk = ~n_clk;
        n_pre = ($urandom_range(0, 7) != 0);
        n_clr = ($urandom_range(0, 7) != 0);
        n_oe  = 1'($urandom);
        n_pin = 1'($urandom);
        step();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule